// File: doc/BRIEF.md
# Byte-Serial Four-Phase Event Link

This block moves 32-bit event packets between two chips over a narrow, pin-limited path: an 8-bit data bus plus a request and an acknowledge wire using a return-to-zero (four-phase) handshake. It has two halves.

The transmit half takes a packet from a valid/ready source inside the chip. It sends the packet as four byte transactions, starting with the most significant byte. The receive half captures the bytes one handshake at a time and rebuilds the packet. It offers the finished packet on a valid/ready output.

The two chips do not share a clock. For that reason, the handshake wire arriving at each half passes through a two-flop synchronizer before any logic uses it. The block only carries bits. It does not look at the meaning of any packet field.

Top module: `aer_byte_link`

## Requirements
- R1: The transmit side raises `tx_ready` only while it is idle. A packet is taken on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low from then until the fourth handshake has fully returned to zero.
- R2: Each accepted packet produces exactly four request pulses on `tx_bus_req`. The bytes go out in the order bits [31:24], [23:16], [15:8], [7:0].
- R3: `tx_bus_data` holds the byte for at least one cycle before `tx_bus_req` rises. It stays unchanged while `tx_bus_req` is high, and for the cycle after.
- R4: `tx_bus_req` rises only while the synchronized acknowledge is low. It falls only after the synchronized acknowledge has been seen high.
- R5: `tx_bus_ack` passes two synchronizer flops. As a result, `tx_bus_req` falls on the third rising clock edge after `tx_bus_ack` goes high at the pin.
- R6: The receive side captures `rx_bus_data` and raises `rx_bus_ack` only after its synchronized request is high. It lowers `rx_bus_ack` only after the synchronized request is low. `rx_bus_req` passes two synchronizer flops: with no packet waiting at the output, `rx_bus_ack` rises on the third rising edge after `rx_bus_req` rises at the pin.
- R7: `rx_valid` rises only once the fourth byte's handshake has completed, meaning `rx_bus_ack` is low again. `rx_packet` then holds the four bytes, with the first-received byte in bits [31:24].
- R8: While `rx_valid` is high and `rx_ready` is low, `rx_packet` and `rx_valid` hold. No new byte is acknowledged until the packet is taken.
- R9: During reset, `tx_bus_req` and `rx_bus_ack` are low, `tx_ready` is high and `rx_valid` is low.
- R10: Packets arrive at the receive output unchanged and in the order they were accepted, whatever the delays on the handshake wires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | A packet to send is present |
| tx_ready | output | 1 | Transmit side is idle and can take a packet |
| tx_packet | input | 32 | Packet to send |
| tx_bus_data | output | 8 | Byte driven toward the remote chip |
| tx_bus_req | output | 1 | Request for the current outgoing byte |
| tx_bus_ack | input | 1 | Acknowledge from the remote chip (asynchronous) |
| rx_bus_data | input | 8 | Byte arriving from the remote chip |
| rx_bus_req | input | 1 | Request from the remote chip (asynchronous) |
| rx_bus_ack | output | 1 | Acknowledge for the incoming byte |
| rx_valid | output | 1 | A rebuilt packet is available |
| rx_ready | input | 1 | Consumer takes the packet |
| rx_packet | output | 32 | Rebuilt packet |

## Verification
The assertions take for granted that the remote side obeys the handshake:
- It moves the acknowledge only in response to a request level.
- It keeps `rx_bus_data` stable from before its request rises until the local acknowledge has been synchronized.

The stimulus keeps within this by looping the transmit half into the receive half. Each handshake wire is delayed by a random zero to three cycles, and the data path is not delayed. Because the data is not delayed, the bytes always settle before the delayed request. Consumer back-pressure is random, with phases where the output is stalled for long runs.

// File: rtl/aer_link_pkg.sv
package aer_link_pkg;
  typedef enum logic [1:0] {
    TX_IDLE    = 2'd0,
    TX_SETUP   = 2'd1,
    TX_REQ     = 2'd2,
    TX_RELEASE = 2'd3
  } tx_state_e;

  typedef enum logic {
    RX_WAIT_REQ = 1'b0,
    RX_WAIT_REL = 1'b1
  } rx_state_e;
endpackage

// File: rtl/aer_link_sync.sv
module aer_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/aer_link_tx.sv
module aer_link_tx
  import aer_link_pkg::*;
#(
  parameter int PKT_W       = 32,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PKT_W-1:0]  in_data,
  output logic [BYTE_W-1:0] bus_data,
  output logic              bus_req,
  input  logic              bus_ack
);
  localparam int BEATS = PKT_W / BYTE_W;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  tx_state_e        state_q, state_d;
  logic [PKT_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             ack_s;

  aer_link_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (bus_ack),
    .q    (ack_s)
  );

  always_comb begin
    state_d = state_q;
    shift_d = shift_q;
    cnt_d   = cnt_q;
    req_d   = req_q;
    unique case (state_q)
      TX_IDLE: begin
        if (in_valid) begin
          shift_d = in_data;
          cnt_d   = '0;
          state_d = TX_SETUP;
        end
      end
      TX_SETUP: begin
        req_d   = 1'b1;
        state_d = TX_REQ;
      end
      TX_REQ: begin
        if (ack_s) begin
          req_d   = 1'b0;
          state_d = TX_RELEASE;
        end
      end
      TX_RELEASE: begin
        if (!ack_s) begin
          if (cnt_q == LAST) begin
            state_d = TX_IDLE;
          end else begin
            shift_d = shift_q << BYTE_W;
            cnt_d   = cnt_q + 1'b1;
            state_d = TX_SETUP;
          end
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      shift_q <= '0;
      cnt_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      req_q   <= req_d;
    end
  end

  assign in_ready = (state_q == TX_IDLE);
  assign bus_data = shift_q[PKT_W-1 -: BYTE_W];
  assign bus_req  = req_q;

  AST_TX_SETUP_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $stable(bus_data)); // R3
  AST_TX_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> $stable(bus_data)); // R3
  AST_TX_RISE_ON_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !ack_s); // R4
  AST_TX_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(ack_s)); // R4
  AST_TX_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !bus_req); // R1
endmodule

// File: rtl/aer_link_rx.sv
module aer_link_rx
  import aer_link_pkg::*;
#(
  parameter int PKT_W       = 32,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] bus_data,
  input  logic              bus_req,
  output logic              bus_ack,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PKT_W-1:0]  out_data
);
  localparam int BEATS = PKT_W / BYTE_W;
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  rx_state_e        state_q, state_d;
  logic [PKT_W-1:0] asm_q, asm_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ack_q, ack_d;
  logic             vld_q, vld_d;
  logic             req_s;

  aer_link_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (bus_req),
    .q    (req_s)
  );

  always_comb begin
    state_d = state_q;
    asm_d   = asm_q;
    cnt_d   = cnt_q;
    ack_d   = ack_q;
    vld_d   = vld_q;
    if (vld_q && out_ready) vld_d = 1'b0;
    unique case (state_q)
      RX_WAIT_REQ: begin
        if (req_s && !vld_q) begin
          asm_d   = {asm_q[PKT_W-BYTE_W-1:0], bus_data};
          ack_d   = 1'b1;
          state_d = RX_WAIT_REL;
        end
      end
      RX_WAIT_REL: begin
        if (!req_s) begin
          ack_d   = 1'b0;
          state_d = RX_WAIT_REQ;
          if (cnt_q == LAST) begin
            cnt_d = '0;
            vld_d = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = RX_WAIT_REQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_WAIT_REQ;
      asm_q   <= '0;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      asm_q   <= asm_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
      vld_q   <= vld_d;
    end
  end

  assign bus_ack   = ack_q;
  assign out_valid = vld_q;
  assign out_data  = asm_q;

  AST_RX_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(req_s)); // R6
  AST_RX_ACK_DROP_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack) |-> !$past(req_s)); // R6
  AST_RX_VALID_AFTER_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !bus_ack); // R7
  AST_RX_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_RX_NO_ACK_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> !$past(out_valid)); // R8
endmodule

// File: rtl/aer_byte_link.sv
module aer_byte_link #(
  parameter int PKT_W       = 32,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [PKT_W-1:0]  tx_packet,
  output logic [BYTE_W-1:0] tx_bus_data,
  output logic              tx_bus_req,
  input  logic              tx_bus_ack,
  input  logic [BYTE_W-1:0] rx_bus_data,
  input  logic              rx_bus_req,
  output logic              rx_bus_ack,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [PKT_W-1:0]  rx_packet
);
  aer_link_tx #(.PKT_W(PKT_W), .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) i_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(tx_valid),
    .in_ready(tx_ready),
    .in_data (tx_packet),
    .bus_data(tx_bus_data),
    .bus_req (tx_bus_req),
    .bus_ack (tx_bus_ack)
  );

  aer_link_rx #(.PKT_W(PKT_W), .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_data (rx_bus_data),
    .bus_req  (rx_bus_req),
    .bus_ack  (rx_bus_ack),
    .out_valid(rx_valid),
    .out_ready(rx_ready),
    .out_data (rx_packet)
  );
endmodule

// File: tb/test_aer_byte_link.sv
module test_aer_byte_link;
  localparam int CLK_PERIOD = 10;
  localparam int NPKT       = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [31:0] tx_packet = '0;
  logic [7:0]  tx_bus_data;
  logic        tx_bus_req;
  logic        tx_bus_ack = 1'b0;
  logic        rx_bus_req = 1'b0;
  logic        rx_bus_ack;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [31:0] rx_packet;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int req_rises = 0;
  int stall_mode = 0;
  bit done = 1'b0;

  logic [31:0] exp_pkts[$];
  logic [7:0]  exp_bytes[$];

  aer_byte_link i_aer_byte_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_packet  (tx_packet),
    .tx_bus_data(tx_bus_data),
    .tx_bus_req (tx_bus_req),
    .tx_bus_ack (tx_bus_ack),
    .rx_bus_data(tx_bus_data),
    .rx_bus_req (rx_bus_req),
    .rx_bus_ack (rx_bus_ack),
    .rx_valid   (rx_valid),
    .rx_ready   (rx_ready),
    .rx_packet  (rx_packet)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // handshake wires with random delay between the two halves
  initial forever begin
    @(tx_bus_req);
    repeat ($urandom_range(0, 3)) @(posedge clk);
    #1 rx_bus_req = tx_bus_req;
  end
  initial forever begin
    @(rx_bus_ack);
    repeat ($urandom_range(0, 3)) @(posedge clk);
    #1 tx_bus_ack = rx_bus_ack;
  end

  // consumer back-pressure
  initial forever begin
    @(posedge clk);
    #1;
    if (stall_mode == 0) rx_ready = 1'b1;
    else if (stall_mode == 1) rx_ready = ($urandom_range(0, 9) < 3);
    else rx_ready = ($urandom_range(0, 19) == 0);
  end

  task automatic send(input logic [31:0] p);
    bit rdy;
    tx_valid  = 1'b1;
    tx_packet = p;
    forever begin
      @(negedge clk);
      rdy = tx_ready;
      @(posedge clk);
      #1;
      if (rdy) break;
    end
    exp_pkts.push_back(p);
    for (int b = 3; b >= 0; b--) exp_bytes.push_back(p[b*8 +: 8]);
    tx_valid = 1'b0;
    repeat ($urandom_range(0, 2)) @(posedge clk);
    #1;
  endtask

  // monitor
  logic       p_req = 1'b0, p_ack = 1'b0, p_rreq = 1'b0, p_rack = 1'b0, p_vld = 1'b0;
  logic       p_stall = 1'b0;
  logic [7:0] p_data = '0;
  logic [31:0] p_pkt = '0;
  int ack_rise_cyc = 0, rreq_rise_cyc = 0;
  bit rreq_free = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      check(tx_bus_req == 1'b0, "R9 tx_bus_req in reset", tx_bus_req, 0);
      check(rx_bus_ack == 1'b0, "R9 rx_bus_ack in reset", rx_bus_ack, 0);
      check(tx_ready == 1'b1,   "R9 tx_ready in reset", tx_ready, 1);
      check(rx_valid == 1'b0,   "R9 rx_valid in reset", rx_valid, 0);
    end else begin
      if (tx_bus_req) check(!tx_ready, "R1 tx_ready low while busy", tx_ready, 0);
      if (tx_bus_req && !p_req) begin
        req_rises++;
        check(tx_bus_data == p_data, "R3 data settled before req", tx_bus_data, p_data);
        if (exp_bytes.size() == 0) check(1'b0, "R2 unexpected byte", tx_bus_data, 0);
        else check(tx_bus_data == exp_bytes.pop_front(), "R2 byte order", tx_bus_data, tx_bus_data ^ 8'hff);
      end
      if (p_req && tx_bus_data != p_data)
        check(1'b0, "R3 data changed while req high", tx_bus_data, p_data);
      if (tx_bus_ack && !p_ack) ack_rise_cyc = cyc;
      if (!tx_bus_req && p_req) begin
        check(tx_bus_ack, "R4 req fell without ack", tx_bus_ack, 1);
        check(cyc - ack_rise_cyc == 3, "R5 ack sync latency", cyc - ack_rise_cyc, 3);
      end
      if (rx_bus_req && !p_rreq) begin
        rreq_rise_cyc = cyc;
        rreq_free = !rx_valid;
      end
      if (rx_bus_ack && !p_rack) begin
        check(rx_bus_req, "R6 ack rose without req", rx_bus_ack, 1);
        check(!p_vld, "R8 ack while packet pending", p_vld, 0);
        if (rreq_free) check(cyc - rreq_rise_cyc == 3, "R6 req sync latency", cyc - rreq_rise_cyc, 3);
      end
      if (!rx_bus_ack && p_rack) check(!rx_bus_req, "R6 ack fell with req high", rx_bus_req, 0);
      if (rx_valid && !p_vld) check(!rx_bus_ack, "R7 valid before final release", rx_bus_ack, 0);
      if (p_stall) begin
        check(rx_valid, "R8 valid dropped while stalled", rx_valid, 1);
        check(rx_packet == p_pkt, "R8 packet changed while stalled", rx_packet, p_pkt);
      end
      if (rx_valid && rx_ready) begin
        if (exp_pkts.size() == 0) check(1'b0, "R10 unexpected packet", rx_packet, 0);
        else begin
          logic [31:0] e;
          e = exp_pkts.pop_front();
          check(rx_packet == e, "R7 R10 packet content and order", rx_packet, e);
        end
      end
    end
    p_req   = tx_bus_req;
    p_ack   = tx_bus_ack;
    p_rreq  = rx_bus_req;
    p_rack  = rx_bus_ack;
    p_vld   = rx_valid;
    p_data  = tx_bus_data;
    p_pkt   = rx_packet;
    p_stall = rst_n && rx_valid && !rx_ready;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    send(32'h0000_0000);
    send(32'hFFFF_FFFF);
    send(32'h0102_0304);
    send(32'h8000_0001);
    send(32'hA5C3_3C5A);
    for (int i = 0; i < NPKT; i++) begin
      stall_mode = (i / 10) % 3;
      send($urandom());
    end
    stall_mode = 0;
    while (exp_pkts.size() != 0) @(posedge clk);
    repeat (20) @(posedge clk);
    check(exp_bytes.size() == 0, "R2 all bytes sent", exp_bytes.size(), 0);
    check(req_rises == 4 * (NPKT + 5), "R2 four transfers per packet", req_rises, 4 * (NPKT + 5));
    check(!rx_valid && !rx_bus_ack && !tx_bus_req && tx_ready, "R1 link idle at end",
          {rx_valid, rx_bus_ack, tx_bus_req, tx_ready}, 4'b0001);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, pending packets=%0d expected=0", exp_pkts.size());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule